// File: doc/BRIEF.md
# Buffered Program Command Sequencer

This block decodes host bus writes for a flash-style memory controller and runs a session-based buffered programming mode. A three-write unlock sequence moves it from read mode into buffered mode. There, a setup write opens a load phase in which the host streams one full page of address/data words, at strictly ascending low addresses, into a write buffer. A confirm write then commits the buffer into a behavioural memory array. Each word is merged into the stored word with a bitwise OR. The block then holds a busy flag for a fixed programming time and returns to idle within buffered mode.

Any sequence violation during loading or confirmation locks the block in an abort state. Only a dedicated reset command releases that state, and it leads back to buffered-mode idle, not to read mode. A two-write exit command leaves buffered mode. Reads issued in read mode return array contents. Reads issued in buffered mode return a status word: a ready bit, a toggle bit that flips on each read while busy, a sticky program-fail bit, and an abort bit.

Top module: `bufprog_seq`

## Requirements
- R1: After reset the block is in read mode with busy low, the array reads as all zeros, and a read returns its data on the cycle after the read strobe.
- R2: In read mode, the setup (0x33), confirm (0x29), abort-reset (0xF0) and exit (0x90) command values are ignored, and reads keep returning array data.
- R3: Writing 0xAA to low address 0x555, then 0x55 to 0x2AA, then 0x20 to 0x555 enters buffered mode. A read then returns the status word, which has bit 7 ready, bit 6 toggle, bit 5 fail, bit 1 abort and all other bits zero, and reads 0x0080 when idle.
- R4: In buffered-mode idle, any write whose low data byte is neither 0x33 nor 0x90 is ignored, and the status stays 0x0080.
- R5: Setup (0x33), followed by 2^PAGE_BITS writes whose low address bits run 0 upward one by one, followed by confirm 0x29, ORs every buffered word into the page named by the address bits above the page offset. The block then returns to buffered-mode idle.
- R6: During loading, a low address that is not exactly the next expected offset, whether it skips ahead, repeats, or does not start at 0, puts the block in abort: the status reads 0x0082 and the array is unchanged.
- R7: During loading, a word whose upper address bits differ from those of the first loaded word causes abort.
- R8: After the last word is loaded, a write with any low data byte other than 0x29 causes abort.
- R9: In abort, every write other than low data byte 0xF0 is ignored, including the exit pair. A 0xF0 write clears the abort bit and returns to buffered-mode idle, where the status reads 0x0080.
- R10: Busy rises on the cycle after the confirm write and stays high for exactly 2^PAGE_BITS + PROG_CYCLES cycles. Writes made while busy are ignored.
- R11: While busy, status reads show bit 7 low, and bit 6 alternates from one status read to the next.
- R12: Status bit 5 is set when some committed word has a stored 1 where the new data holds a 0. It is cleared by the next setup write.
- R13: Writing 0x90 then 0x00 in buffered-mode idle returns to read mode. If 0x90 is followed by any other value, the block stays in buffered mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| we | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| addr | input | ADDR_W | Bus address for reads and writes |
| wdata | input | DATA_W | Write data; the command code is in bits 7:0 |
| rdata | output | DATA_W | Registered read data: array word in read mode, status word in buffered mode |
| busy | output | 1 | High while a confirmed page is being programmed |

## Verification
A wrong sequencer state shows up at the next status read as a wrong ready or abort bit. It also shows up as array data returned where a status word is expected, or the reverse, so every step of the bench follows its writes with a read. A load counter or page latch that is off by one does not show up at once. It shows up at confirm time, either as an abort that should not happen or as a missing one. A bad commit index shows up as wrong array contents, and those are only visible after the exit command, when the whole array is swept. A miscounted programming timer shows up as a busy pulse of the wrong length, measured at the port.

// File: rtl/bp_pkg.sv
// Package: shared state encoding and fixed command codes for the
// buffered program command sequencer. Assumes commands sit in wdata[7:0].
package bp_pkg;
    typedef enum logic [3:0] {
        ST_READ,
        ST_UNLK1,
        ST_UNLK2,
        ST_IDLE,
        ST_EXIT1,
        ST_LOAD,
        ST_CONFIRM,
        ST_BUSY,
        ST_ABORT
    } bp_state_e;

    localparam logic [7:0]  CMD_UNLK_A    = 8'hAA;
    localparam logic [7:0]  CMD_UNLK_B    = 8'h55;
    localparam logic [7:0]  CMD_ENTER     = 8'h20;
    localparam logic [7:0]  CMD_SETUP     = 8'h33;
    localparam logic [7:0]  CMD_CONFIRM   = 8'h29;
    localparam logic [7:0]  CMD_ABORT_RST = 8'hF0;
    localparam logic [7:0]  CMD_EXIT_A    = 8'h90;
    localparam logic [7:0]  CMD_EXIT_B    = 8'h00;
    localparam logic [11:0] UNLK_ADDR1    = 12'h555;
    localparam logic [11:0] UNLK_ADDR2    = 12'h2AA;
endpackage

// File: rtl/bp_fsm.sv
// Module: command sequencer. Decodes bus writes, tracks the load offset and
// page, runs the programming timer and keeps the sticky fail flag.
// Assumes one write per strobe cycle, ADDR_W >= 12 and PROG_CYCLES >= 1.
module bp_fsm
    import bp_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int PAGE_BITS   = 8,
    parameter int MPG_W       = 2,
    parameter int PROG_CYCLES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [7:0]             cmd,
    input  logic                   commit_fail,
    output bp_state_e              state,
    output logic                   load_en,
    output logic [PAGE_BITS-1:0]   load_idx,
    output logic                   commit_en,
    output logic [PAGE_BITS-1:0]   commit_idx,
    output logic [MPG_W-1:0]       commit_page,
    output logic                   fail_flag
);
    localparam int WORDS = 1 << PAGE_BITS;
    localparam int TOTAL = WORDS + PROG_CYCLES;
    localparam int CNT_W = $clog2(TOTAL);
    localparam int HI_W  = ADDR_W - PAGE_BITS;
    localparam logic [PAGE_BITS-1:0] LAST_IDX = PAGE_BITS'(WORDS - 1);
    localparam logic [CNT_W-1:0]     LAST_CNT = CNT_W'(TOTAL - 1);
    localparam logic [CNT_W-1:0]     WORDS_C  = CNT_W'(WORDS);

    bp_state_e            state_n;
    logic [PAGE_BITS-1:0] idx_q;
    logic [HI_W-1:0]      page_q;
    logic [CNT_W-1:0]     cnt_q;
    logic                 load_ok;
    logic                 setup_acc;
    logic [11:0]          lo12;

    assign lo12      = addr[11:0];
    assign load_ok   = (addr[PAGE_BITS-1:0] == idx_q) &&
                       ((idx_q == '0) || (addr[ADDR_W-1:PAGE_BITS] == page_q));
    assign setup_acc = (state == ST_IDLE) && we && (cmd == CMD_SETUP);
    assign load_en   = (state == ST_LOAD) && we && load_ok;
    assign load_idx  = idx_q;
    assign commit_en   = (state == ST_BUSY) && (cnt_q < WORDS_C);
    assign commit_idx  = cnt_q[PAGE_BITS-1:0];
    assign commit_page = page_q[MPG_W-1:0];

    // Next-state decode of the command sequence.
    always_comb begin
        state_n = state;
        case (state)
            ST_READ:    if (we && cmd == CMD_UNLK_A && lo12 == UNLK_ADDR1) state_n = ST_UNLK1;
            ST_UNLK1:   if (we) state_n = (cmd == CMD_UNLK_B && lo12 == UNLK_ADDR2) ? ST_UNLK2 : ST_READ;
            ST_UNLK2:   if (we) state_n = (cmd == CMD_ENTER && lo12 == UNLK_ADDR1) ? ST_IDLE : ST_READ;
            ST_IDLE: begin
                if (we && cmd == CMD_SETUP)       state_n = ST_LOAD;
                else if (we && cmd == CMD_EXIT_A) state_n = ST_EXIT1;
            end
            ST_EXIT1:   if (we) state_n = (cmd == CMD_EXIT_B) ? ST_READ : ST_IDLE;
            ST_LOAD: begin
                if (we && !load_ok)             state_n = ST_ABORT;
                else if (we && idx_q == LAST_IDX) state_n = ST_CONFIRM;
            end
            ST_CONFIRM: if (we) state_n = (cmd == CMD_CONFIRM) ? ST_BUSY : ST_ABORT;
            ST_BUSY:    if (cnt_q == LAST_CNT) state_n = ST_IDLE;
            ST_ABORT:   if (we && cmd == CMD_ABORT_RST) state_n = ST_IDLE;
            default:    state_n = ST_READ;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READ;
        else        state <= state_n;
    end

    // Load offset counter and page latch taken from the first loaded word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            page_q <= '0;
        end else if (setup_acc) begin
            idx_q <= '0;
        end else if (load_en) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == '0) page_q <= addr[ADDR_W-1:PAGE_BITS];
        end
    end

    // Programming timer: commit phase then settle phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (state != ST_BUSY) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end

    // Sticky program-fail flag, cleared by each accepted setup.
    always_ff @(posedge clk) begin
        if (!rst_n)                         fail_flag <= 1'b0;
        else if (setup_acc)                 fail_flag <= 1'b0;
        else if (commit_en && commit_fail)  fail_flag <= 1'b1;
    end
endmodule

// File: rtl/bp_store.sv
// Module: write buffer plus behavioural memory array. Commits one buffered
// word per cycle with an OR merge and flags stored ones the new data clears.
// Assumes MEM_PAGES is a power of two; the write buffer is not reset.
module bp_store #(
    parameter int DATA_W    = 16,
    parameter int PAGE_BITS = 8,
    parameter int MPG_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_en,
    input  logic [PAGE_BITS-1:0]       load_idx,
    input  logic [DATA_W-1:0]          load_data,
    input  logic                       commit_en,
    input  logic [PAGE_BITS-1:0]       commit_idx,
    input  logic [MPG_W-1:0]           commit_page,
    input  logic [MPG_W+PAGE_BITS-1:0] rd_addr,
    output logic [DATA_W-1:0]          rd_word,
    output logic                       commit_fail
);
    localparam int WORDS = 1 << PAGE_BITS;
    localparam int DEPTH = WORDS << MPG_W;

    logic [DATA_W-1:0]          buf_q [WORDS];
    logic [DATA_W-1:0]          mem_q [DEPTH];
    logic [MPG_W+PAGE_BITS-1:0] caddr;
    logic [DATA_W-1:0]          cur_word;
    logic [DATA_W-1:0]          new_word;

    assign caddr       = {commit_page, commit_idx};
    assign cur_word    = mem_q[caddr];
    assign new_word    = buf_q[commit_idx];
    assign commit_fail = |(cur_word & ~new_word);
    assign rd_word     = mem_q[rd_addr];

    // Capture loaded words into the write buffer.
    always_ff @(posedge clk) begin
        if (load_en) buf_q[load_idx] <= load_data;
    end

    // Clear the array on reset; OR-merge one buffered word per commit cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (commit_en) begin
            mem_q[caddr] <= cur_word | new_word;
        end
    end
endmodule

// File: rtl/bp_status.sv
// Module: read-data register. Returns array data in read mode and the status
// word in buffered mode; the toggle bit flips on each status read while busy.
// Assumes DATA_W >= 8.
module bp_status #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              in_mode,
    input  logic              busy,
    input  logic              fail,
    input  logic              abort,
    input  logic [DATA_W-1:0] mem_word,
    output logic [DATA_W-1:0] rdata
);
    logic              tog_q;
    logic [DATA_W-1:0] stat_word;

    // Assemble the status word from the live flags.
    always_comb begin
        stat_word    = '0;
        stat_word[7] = ~busy;
        stat_word[6] = tog_q & busy;
        stat_word[5] = fail;
        stat_word[1] = abort;
    end

    // Register read data and advance the toggle bit on busy status reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            tog_q <= 1'b0;
        end else if (rd_en) begin
            rdata <= in_mode ? stat_word : mem_word;
            if (in_mode && busy) tog_q <= ~tog_q;
        end
    end
endmodule

// File: rtl/bufprog_seq.sv
// Module: top of the buffered program command sequencer. Joins the command
// sequencer, the buffer/array store and the read-data register.
// Assumes ADDR_W >= 12, PAGE_BITS + log2(MEM_PAGES) <= ADDR_W, MEM_PAGES >= 2.
module bufprog_seq
    import bp_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 16,
    parameter int PAGE_BITS   = 8,
    parameter int MEM_PAGES   = 4,
    parameter int PROG_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy
);
    localparam int MPG_W    = $clog2(MEM_PAGES);
    localparam int BUSY_LEN = (1 << PAGE_BITS) + PROG_CYCLES;

    bp_state_e            st;
    logic                 load_en;
    logic [PAGE_BITS-1:0] load_idx;
    logic                 commit_en;
    logic [PAGE_BITS-1:0] commit_idx;
    logic [MPG_W-1:0]     commit_page;
    logic                 commit_fail;
    logic                 fail_flag;
    logic [DATA_W-1:0]    rd_word;
    logic                 in_mode;

    assign busy    = (st == ST_BUSY);
    assign in_mode = !(st inside {ST_READ, ST_UNLK1, ST_UNLK2});

    bp_fsm #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
        .MPG_W(MPG_W), .PROG_CYCLES(PROG_CYCLES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .cmd(wdata[7:0]),
        .commit_fail(commit_fail), .state(st), .load_en(load_en),
        .load_idx(load_idx), .commit_en(commit_en), .commit_idx(commit_idx),
        .commit_page(commit_page), .fail_flag(fail_flag)
    );

    bp_store #(
        .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS), .MPG_W(MPG_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
        .load_data(wdata), .commit_en(commit_en), .commit_idx(commit_idx),
        .commit_page(commit_page), .rd_addr(addr[MPG_W+PAGE_BITS-1:0]),
        .rd_word(rd_word), .commit_fail(commit_fail)
    );

    bp_status #(
        .DATA_W(DATA_W)
    ) u_status (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .in_mode(in_mode),
        .busy(busy), .fail(fail_flag), .abort(st == ST_ABORT),
        .mem_word(rd_word), .rdata(rdata)
    );
endmodule

// File: rtl/bp_chk.sv
// Module: property checker bound to bufprog_seq. Watches busy length,
// status bits during programming, abort locking and the exit sequence.
module bp_chk
    import bp_pkg::*;
#(
    parameter int BUSY_LEN = 272
) (
    input logic       clk,
    input logic       rst_n,
    input logic       we,
    input logic       rd_en,
    input logic       busy,
    input logic [7:0] cmd,
    input logic [1:0] rflags,
    input bp_state_e  st
);
    int unsigned bcnt;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    bcnt <= 0;
        else if (busy) bcnt <= bcnt + 1;
        else           bcnt <= 0;
    end

    // R10
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == BUSY_LEN));

    // R11
    ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> !rflags[1]);

    // R11
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && $past(rd_en && busy)) |=> (rflags[0] != $past(rflags[0])));

    // R9
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ABORT && !(we && cmd == CMD_ABORT_RST)) |=> (st == ST_ABORT));

    // R13
    exit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EXIT1 && we && cmd == CMD_EXIT_B) |=> (st == ST_READ));
endmodule

bind bufprog_seq bp_chk #(.BUSY_LEN(BUSY_LEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .we(we), .rd_en(rd_en), .busy(busy),
    .cmd(wdata[7:0]), .rflags(rdata[7:6]), .st(st)
);

// File: tb/tb_bufprog_seq.sv
module tb_bufprog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 24;
    localparam int DATA_W     = 16;
    localparam int PAGE_BITS  = 8;
    localparam int MEM_PAGES  = 4;
    localparam int PROG       = 16;
    localparam int WORDS      = 1 << PAGE_BITS;
    localparam int TOTAL      = WORDS + PROG;
    localparam logic [15:0] ST_IDLE_V  = 16'h0080;
    localparam logic [15:0] ST_ABORT_V = 16'h0082;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              we = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              busy;

    int nchk = 0;
    int nfail = 0;
    logic [15:0] exp_mem [WORDS*MEM_PAGES];

    always #(CLK_PERIOD/2) clk = ~clk;

    bufprog_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS),
        .MEM_PAGES(MEM_PAGES), .PROG_CYCLES(PROG)
    ) dut (
        .clk(clk), .rst_n(rst_n), .we(we), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [23:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    function automatic logic [15:0] pat(input int p, input int i, input int s);
        return 16'((i * 257 + p * 4099 + s * 31) ^ (s << 4));
    endfunction

    task automatic enter();
        wr(24'h000555, 16'h00AA);
        wr(24'h0002AA, 16'h0055);
        wr(24'h000555, 16'h0020);
    endtask

    task automatic load_page(input int p, input int s);
        wr(24'(p << 8), 16'h0033);
        for (int i = 0; i < WORDS; i++) wr(24'((p << 8) | i), pat(p, i, s));
    endtask

    // Update the model for a commit; returns the expected fail bit.
    function automatic logic model_commit(input int p, input int s);
        logic f = 1'b0;
        for (int i = 0; i < WORDS; i++) begin
            if ((exp_mem[p*WORDS+i] & ~pat(p, i, s)) != 0) f = 1'b1;
            exp_mem[p*WORDS+i] = exp_mem[p*WORDS+i] | pat(p, i, s);
        end
        return f;
    endfunction

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic sweep(input string tag);
        logic [15:0] v;
        for (int p = 0; p < MEM_PAGES; p++)
            for (int i = 0; i < WORDS; i++) begin
                rd(24'((p << 8) | i), v);
                check(tag, 32'(v), 32'(exp_mem[p*WORDS+i]));
            end
    endtask

    task automatic abort_release(input string tag);
        logic [15:0] v;
        rd(24'h0, v);
        check({tag, " abort status"}, 32'(v), 32'(ST_ABORT_V));
        wr(24'h0, 16'h0090);
        wr(24'h0, 16'h0000);
        wr(24'h0, 16'h0033);
        rd(24'h0, v);
        check("R9 abort ignores other writes", 32'(v), 32'(ST_ABORT_V));
        wr(24'h0, 16'h00F0);
        rd(24'h0, v);
        check("R9 abort reset to mode idle", 32'(v), 32'(ST_IDLE_V));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired, run hung");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        logic [15:0] v, v1, v2, v3;
        logic        f;
        int          n;
        for (int k = 0; k < WORDS*MEM_PAGES; k++) exp_mem[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 busy after reset", 32'(busy), 32'd0);
        rd(24'h000123, v);
        check("R1 array zero after reset", 32'(v), 32'd0);

        // R2: buffered commands ignored in read mode
        wr(24'h000555, 16'h0033);
        wr(24'h0, 16'h0029);
        wr(24'h0, 16'h00F0);
        wr(24'h0, 16'h0090);
        rd(24'h0, v);
        check("R2 read mode kept", 32'(v), 32'd0);
        check("R2 no busy", 32'(busy), 32'd0);

        // R3: entry
        enter();
        rd(24'h0, v);
        check("R3 status after entry", 32'(v), 32'(ST_IDLE_V));

        // R4: other commands ignored in mode idle
        wr(24'h000555, 16'h00AA);
        wr(24'h0, 16'h0020);
        wr(24'h0, 16'h00A0);
        wr(24'h0, 16'h0029);
        rd(24'h0, v);
        check("R4 mode idle kept", 32'(v), 32'(ST_IDLE_V));

        // R5/R10: program page 1, measure busy length
        load_page(1, 1);
        wr(24'h000100, 16'h0029);
        f = model_commit(1, 1);
        n = 0;
        while (busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
        check("R10 busy length", 32'(n), 32'(TOTAL));
        rd(24'h0, v);
        check("R5 back to mode idle", 32'(v), 32'(ST_IDLE_V | (f ? 16'h0020 : 16'h0)));

        // R11/R10: program page 2 with status reads and writes while busy
        load_page(2, 2);
        wr(24'h000200, 16'h0029);
        f = model_commit(2, 2);
        rd(24'h0, v1);
        rd(24'h0, v2);
        wr(24'h0, 16'h0090);
        wr(24'h0, 16'h0000);
        rd(24'h0, v3);
        check("R11 ready low while busy", 32'({v1[7], v2[7], v3[7]}), 32'd0);
        check("R11 toggle flips 1-2", 32'(v1[6] ^ v2[6]), 32'd1);
        check("R11 toggle flips 2-3", 32'(v2[6] ^ v3[6]), 32'd1);
        wait_idle();
        rd(24'h0, v);
        check("R10 writes ignored while busy", 32'(v), 32'(ST_IDLE_V));
        check("R12 no fail on fresh page", 32'(f), 32'd0);

        // R12: reprogram page 1 with conflicting data
        load_page(1, 7);
        wr(24'h000100, 16'h0029);
        f = model_commit(1, 7);
        wait_idle();
        rd(24'h0, v);
        check("R12 fail bit after conflicting program", 32'(v),
              32'(ST_IDLE_V | (f ? 16'h0020 : 16'h0)));
        check("R12 conflict present in pattern", 32'(f), 32'd1);
        wr(24'h000300, 16'h0033);
        for (int i = 0; i < 3; i++) wr(24'(24'h000300 | i), 16'hFFFF);
        wr(24'h000300, 16'hFFFF);
        rd(24'h0, v);
        check("R12 fail cleared by setup", 32'(v & 16'h0020), 32'd0);
        wr(24'h0, 16'h00F0);

        // R13: exit pair
        wr(24'h0, 16'h0090);
        wr(24'h0, 16'h0055);
        rd(24'h0, v);
        check("R13 stays in mode on bad second write", 32'(v), 32'(ST_IDLE_V));
        wr(24'h0, 16'h0090);
        wr(24'h0, 16'h0000);
        sweep("R5 array contents");

        // R6: skipped, repeated and non-zero start offsets
        enter();
        wr(24'h000300, 16'h0033);
        for (int i = 0; i < 5; i++) wr(24'(24'h000300 | i), 16'h1234);
        wr(24'h000306, 16'h1234);
        abort_release("R6 skip");
        wr(24'h000300, 16'h0033);
        for (int i = 0; i < 3; i++) wr(24'(24'h000300 | i), 16'h1234);
        wr(24'h000302, 16'h1234);
        abort_release("R6 repeat");
        wr(24'h000300, 16'h0033);
        wr(24'h000301, 16'h1234);
        abort_release("R6 start not zero");

        // R7: upper address mismatch
        wr(24'h000300, 16'h0033);
        for (int i = 0; i < 10; i++) wr(24'(24'h000300 | i), 16'h5A5A);
        wr(24'h00020A, 16'h5A5A);
        abort_release("R7 page mismatch");

        // R8: bad confirm
        load_page(3, 9);
        wr(24'h000300, 16'h0030);
        abort_release("R8 bad confirm");

        // R6/R7/R8: aborted sessions left the array unchanged
        wr(24'h0, 16'h0090);
        wr(24'h0, 16'h0000);
        sweep("R6 array unchanged after aborts");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule